// File: doc/BRIEF.md
# Per-CPU Interrupt Delivery Port

This block holds the delivery state that one processor sees in a multi-source interrupt controller. A routing unit offers it sources, one per cycle. Each offer carries the source index, its priority, its vector and its trigger kind. The block keeps two bit sets over the sources. The pending set holds sources that were accepted but not yet taken. The in-service set holds sources that the processor has taken and not yet retired. Alongside the sets it keeps a 4-bit task priority threshold and the processor's interrupt line.

The processor works the block through three register accesses:
- An acknowledge read takes the best pending source. It returns that source's vector, or a spurious code if the pending set is empty or the chosen source has gone stale.
- An end-of-interrupt write retires the best in-service source.
- A task-priority write sets the threshold, and the threshold can also be read back.

The block does not store the activity flag of a source. It reads that flag from the source side and returns set and clear requests, each carrying a source index.

Top module: `dlv_cpu_port`

## Requirements
- R1: After reset the interrupt line is low, the threshold reads 0xF, both sets are empty, and an acknowledge returns the spurious code (parameter, default 0xFF).
- R2: An offer whose 5-bit priority is not greater than the threshold is dropped. There is no activity-set request, the line keeps its value, and the source does not enter the pending set.
- R3: An offer for a source that is still in the pending set (after any acknowledge in the same cycle) is dropped. The stored vector is left unchanged.
- R4: An accepted offer raises an activity-set request for its index in the same cycle and joins the pending set. At the next edge the line goes high only if two conditions hold. First, its priority is not below the best pending priority that was present before it. Second, the in-service set is empty or its best priority is strictly lower. Otherwise the line keeps its value.
- R5: The best entry of a set has the highest priority. Among equal priorities the lowest index wins.
- R6: An acknowledge returns its vector combinationally in the same cycle and drops the line at the next edge, unless an end-of-interrupt or an offer in the same cycle raises it again. If the pending set is empty it returns the spurious code.
- R7: The chosen source is stale when its activity input is low or its stored priority does not exceed the threshold. A stale source returns the spurious code and produces an activity-clear request for its index. A source that is not stale moves into the in-service set, and its stored vector is returned.
- R8: An acknowledge always removes the chosen source from the pending set. An edge-triggered source (offer_level = 0; 1 means level-triggered) also produces an activity-clear request.
- R9: An end-of-interrupt removes the best in-service entry. At the next edge the line goes high if the pending set is non-empty and either the in-service set is now empty or the best pending priority is strictly greater than the new best in-service priority.
- R10: A threshold write takes effect at the next edge. Every check in the same cycle uses the old value.
- R11: Within one cycle the acknowledge is applied first, then the end-of-interrupt, then the offer. A rise caused by the offer or the end-of-interrupt overrides the drop caused by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Routing offers a source this cycle |
| offer_idx | input | IDX_W | Index of the offered source |
| offer_prio | input | 5 | Priority of the offered source |
| offer_vec | input | 8 | Vector of the offered source |
| offer_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| src_active | input | N_SRC | Activity flag of each source |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vec | output | 8 | Acknowledge read data |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| tp_wr | input | 1 | Threshold write strobe |
| tp_wdata | input | 4 | Threshold write data |
| tp_rdata | output | 4 | Current threshold |
| irq_out | output | 1 | Interrupt line to the processor |
| act_set_valid | output | 1 | Request to set a source's activity flag |
| act_set_idx | output | IDX_W | Index for the set request |
| act_clr_valid | output | 1 | Request to clear a source's activity flag |
| act_clr_idx | output | IDX_W | Index for the clear request |

## Verification
The checker watches the following on every cycle:
- Dropped offers never request an activity set.
- Clear requests come only from acknowledges.
- An empty pending set yields the spurious code.
- A plain acknowledge lowers the line, and a rising line always has an offer or end-of-interrupt behind it.
- An acknowledge shrinks the pending set by exactly one entry, and an end-of-interrupt shrinks the in-service set by exactly one entry.
- The threshold follows its writes.

Other behaviours depend on history, so only the bench's reference model can show them. These are tie-breaking by lowest index, stale detection after a threshold change or a dropped activity flag, the reassertion rule after an end-of-interrupt, and the same-cycle ordering of acknowledge, end-of-interrupt and offer.

// File: rtl/dlv_pkg.sv
package dlv_pkg;

    localparam int PRIO_W = 5;
    localparam int VEC_W  = 8;
    localparam int TP_W   = 4;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [TP_W-1:0]   tp_t;

    // attributes captured from an accepted offer
    typedef struct packed {
        prio_t prio;
        vec_t  vec;
        logic  level;
    } src_attr_t;

    // outcome of an acknowledge read
    typedef enum logic [1:0] {
        ACK_EMPTY,
        ACK_STALE,
        ACK_TAKE
    } ack_kind_t;

    // priority passes the threshold only when strictly above it
    function automatic logic above_tp(prio_t p, tp_t t);
        return p > prio_t'(t);
    endfunction

    // a candidate is visible over a set whose best entry is 'best'
    function automatic logic beats(prio_t cand, logic best_found, prio_t best, logic allow_equal);
        if (!best_found) return 1'b1;
        return allow_equal ? (cand >= best) : (cand > best);
    endfunction

endpackage

// File: rtl/dlv_pick.sv
module dlv_pick
    import dlv_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] mask,
    input  prio_t            prio [N_SRC],
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output prio_t            best
);

    // strictly-greater scan from index 0: ties keep the lower index
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (mask[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/dlv_attr_store.sv
module dlv_attr_store
    import dlv_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  src_attr_t        wr_attr,
    output src_attr_t        attr [N_SRC],
    output prio_t            prio [N_SRC]
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_ent
        src_attr_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q <= wr_attr;
            end
        end

        assign attr[g] = ent_q;
        assign prio[g] = ent_q.prio;
    end

endmodule

// File: rtl/dlv_cpu_port.sv
module dlv_cpu_port
    import dlv_pkg::*;
#(
    parameter int   N_SRC    = 8,
    parameter vec_t SPUR_VEC = 8'hFF,
    parameter tp_t  TP_RESET = 4'hF,
    localparam int  IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             offer_valid,
    input  logic [IDX_W-1:0] offer_idx,
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [VEC_W-1:0] offer_vec,
    input  logic             offer_level,
    input  logic [N_SRC-1:0] src_active,
    input  logic             ack_rd,
    output logic [VEC_W-1:0] ack_vec,
    input  logic             eoi_wr,
    input  logic             tp_wr,
    input  logic [TP_W-1:0]  tp_wdata,
    output logic [TP_W-1:0]  tp_rdata,
    output logic             irq_out,
    output logic             act_set_valid,
    output logic [IDX_W-1:0] act_set_idx,
    output logic             act_clr_valid,
    output logic [IDX_W-1:0] act_clr_idx
);

    // ---------------- state ----------------
    logic [N_SRC-1:0] raised_q, serv_q;
    logic             irq_q;
    tp_t              tp_q;

    src_attr_t attr [N_SRC];
    prio_t     prio [N_SRC];

    // ---------------- stage 1: acknowledge ----------------
    logic             a_found;
    logic [IDX_W-1:0] a_idx;
    prio_t            a_best;
    ack_kind_t        a_kind;
    src_attr_t        a_attr;
    logic [N_SRC-1:0] raised1, serv1;
    logic             irq1;

    dlv_pick #(.N_SRC(N_SRC)) u_pick_ack (
        .mask(raised_q), .prio(prio), .found(a_found), .idx(a_idx), .best(a_best)
    );

    assign a_attr = attr[a_idx];

    always_comb begin
        if (!a_found)
            a_kind = ACK_EMPTY;
        else if (!src_active[a_idx] || !above_tp(a_best, tp_q))
            a_kind = ACK_STALE;
        else
            a_kind = ACK_TAKE;
    end

    always_comb begin
        raised1 = raised_q;
        serv1   = serv_q;
        if (ack_rd && a_found) begin
            raised1[a_idx] = 1'b0;
            if (a_kind == ACK_TAKE)
                serv1[a_idx] = 1'b1;
        end
    end

    assign irq1          = ack_rd ? 1'b0 : irq_q;
    assign ack_vec       = (a_kind == ACK_TAKE) ? a_attr.vec : SPUR_VEC;
    assign act_clr_valid = ack_rd && a_found && (a_kind == ACK_STALE || !a_attr.level);
    assign act_clr_idx   = a_idx;

    // ---------------- stage 2: end of interrupt ----------------
    logic             e_found;
    logic [IDX_W-1:0] e_idx;
    prio_t            e_best;
    logic [N_SRC-1:0] serv2;

    dlv_pick #(.N_SRC(N_SRC)) u_pick_eoi (
        .mask(serv1), .prio(prio), .found(e_found), .idx(e_idx), .best(e_best)
    );

    always_comb begin
        serv2 = serv1;
        if (eoi_wr && e_found)
            serv2[e_idx] = 1'b0;
    end

    // best pending after the acknowledge, best in service after the retire
    logic             r_found, s_found;
    logic [IDX_W-1:0] r_idx, s_idx;
    prio_t            r_best, s_best;

    dlv_pick #(.N_SRC(N_SRC)) u_pick_rais (
        .mask(raised1), .prio(prio), .found(r_found), .idx(r_idx), .best(r_best)
    );

    dlv_pick #(.N_SRC(N_SRC)) u_pick_serv (
        .mask(serv2), .prio(prio), .found(s_found), .idx(s_idx), .best(s_best)
    );

    logic eoi_raise, irq2;
    assign eoi_raise = eoi_wr && r_found && beats(r_best, s_found, s_best, 1'b0);
    assign irq2      = irq1 | eoi_raise;

    // ---------------- stage 3: offer ----------------
    logic offer_ok, offer_raise;
    logic [N_SRC-1:0] raised_d;

    assign offer_ok    = offer_valid && above_tp(offer_prio, tp_q) && !raised1[offer_idx];
    assign offer_raise = offer_ok
                       && beats(offer_prio, r_found, r_best, 1'b1)
                       && beats(offer_prio, s_found, s_best, 1'b0);

    always_comb begin
        raised_d = raised1;
        if (offer_ok)
            raised_d[offer_idx] = 1'b1;
    end

    assign act_set_valid = offer_ok;
    assign act_set_idx   = offer_idx;

    src_attr_t offer_attr;
    assign offer_attr = '{prio: offer_prio, vec: offer_vec, level: offer_level};

    dlv_attr_store #(.N_SRC(N_SRC)) u_store (
        .clk(clk), .rst(rst), .wr_en(offer_ok), .wr_idx(offer_idx),
        .wr_attr(offer_attr), .attr(attr), .prio(prio)
    );

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q <= '0;
            serv_q   <= '0;
            irq_q    <= 1'b0;
            tp_q     <= TP_RESET;
        end else begin
            raised_q <= raised_d;
            serv_q   <= serv2;
            irq_q    <= irq2 | offer_raise;
            if (tp_wr)
                tp_q <= tp_wdata;
        end
    end

    assign irq_out  = irq_q;
    assign tp_rdata = tp_q;

endmodule

// File: rtl/dlv_cpu_port_chk.sv
module dlv_cpu_port_chk
    import dlv_pkg::*;
#(
    parameter int   N_SRC    = 8,
    parameter vec_t SPUR_VEC = 8'hFF,
    parameter tp_t  TP_RESET = 4'hF,
    localparam int  IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             offer_valid,
    input logic [IDX_W-1:0] offer_idx,
    input logic [PRIO_W-1:0] offer_prio,
    input logic             ack_rd,
    input logic [VEC_W-1:0] ack_vec,
    input logic             eoi_wr,
    input logic             tp_wr,
    input logic [TP_W-1:0]  tp_wdata,
    input logic [TP_W-1:0]  tp_rdata,
    input logic             irq_out,
    input logic             act_set_valid,
    input logic             act_clr_valid,
    input logic [N_SRC-1:0] raised,
    input logic [N_SRC-1:0] serv
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tp_rdata == TP_RESET && !irq_out && raised == '0 && serv == '0));

    assert_low_prio_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && offer_prio <= prio_t'(tp_rdata)) |-> !act_set_valid);

    assert_missed_offer_R3: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !ack_rd && raised[offer_idx]) |-> !act_set_valid);

    assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(offer_valid || eoi_wr));

    assert_ack_drops_line_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !eoi_wr && !offer_valid) |=> !irq_out);

    assert_empty_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && raised == '0) |-> (ack_vec == SPUR_VEC && !act_clr_valid));

    assert_clear_from_ack_R8: assert property (@(posedge clk) disable iff (rst)
        act_clr_valid |-> ack_rd);

    assert_ack_removes_one_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && raised != '0 && !offer_valid) |=>
            ($countones(raised) == $countones($past(raised)) - 1));

    assert_eoi_retires_one_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack_rd && serv != '0) |=>
            ($countones(serv) == $countones($past(serv)) - 1));

    assert_tp_write_R10: assert property (@(posedge clk) disable iff (rst)
        tp_wr |=> (tp_rdata == $past(tp_wdata)));

endmodule

bind dlv_cpu_port dlv_cpu_port_chk #(
    .N_SRC(N_SRC), .SPUR_VEC(SPUR_VEC), .TP_RESET(TP_RESET)
) u_chk (
    .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_idx(offer_idx),
    .offer_prio(offer_prio), .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
    .tp_wr(tp_wr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .irq_out(irq_out),
    .act_set_valid(act_set_valid), .act_clr_valid(act_clr_valid),
    .raised(raised_q), .serv(serv_q)
);

// File: tb/sim_dlv_cpu_port.sv
module sim_dlv_cpu_port;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int SPUR  = 8'hFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic          offer_valid = 0, offer_level = 0, ack_rd = 0, eoi_wr = 0, tp_wr = 0;
    logic [IW-1:0] offer_idx = '0;
    logic [4:0]    offer_prio = '0;
    logic [7:0]    offer_vec = '0;
    logic [3:0]    tp_wdata = '0;
    logic [N-1:0]  src_active;
    logic [7:0]    ack_vec;
    logic [3:0]    tp_rdata;
    logic          irq_out, act_set_valid, act_clr_valid;
    logic [IW-1:0] act_set_idx, act_clr_idx;

    dlv_cpu_port #(.N_SRC(N)) u0 (
        .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_idx(offer_idx),
        .offer_prio(offer_prio), .offer_vec(offer_vec), .offer_level(offer_level),
        .src_active(src_active), .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_wr(eoi_wr),
        .tp_wr(tp_wr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata), .irq_out(irq_out),
        .act_set_valid(act_set_valid), .act_set_idx(act_set_idx),
        .act_clr_valid(act_clr_valid), .act_clr_idx(act_clr_idx)
    );

    // reference model state
    bit [N-1:0] m_raised, m_serv, m_act;
    int         m_prio [N];
    int         m_vec  [N];
    bit         m_lvl  [N];
    int         m_tp;
    bit         m_irq;
    assign src_active = m_act;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    function automatic int pick(bit [N-1:0] mask);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < N; i++)
            if (mask[i] && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
        return best;
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic cycle();
        int e_vec = SPUR;
        bit e_clr = 0;
        int e_ci = 0;
        bit e_set = 0;
        bit [N-1:0] r = m_raised;
        bit [N-1:0] s = m_serv;
        bit [N-1:0] a = m_act;
        bit irq = m_irq;
        int sel, hi, sh;
        // acknowledge first (R11)
        if (ack_rd) begin
            irq = 0;
            sel = pick(r);
            if (sel >= 0) begin
                if (!a[sel] || m_prio[sel] <= m_tp) e_clr = 1;
                else begin s[sel] = 1; e_vec = m_vec[sel]; end
                r[sel] = 0;
                if (!m_lvl[sel]) e_clr = 1;
                e_ci = sel;
            end
        end
        // then end of interrupt
        if (eoi_wr) begin
            sh = pick(s);
            if (sh >= 0) s[sh] = 0;
            hi = pick(r);
            sh = pick(s);
            if (hi >= 0 && (sh < 0 || m_prio[hi] > m_prio[sh])) irq = 1;
        end
        // then offer
        if (offer_valid && int'(offer_prio) > m_tp && !r[offer_idx]) begin
            hi = pick(r);
            sh = pick(s);
            e_set = 1;
            if ((hi < 0 || int'(offer_prio) >= m_prio[hi]) &&
                (sh < 0 || int'(offer_prio) > m_prio[sh])) irq = 1;
        end
        if (e_clr) a[e_ci] = 0;

        #(CLK_P/4);
        if (ack_rd) check(ack_vec == e_vec[7:0], "R5 R6 R7 ack vector", ack_vec, e_vec);
        check(act_clr_valid == e_clr, "R7 R8 clear request", act_clr_valid, e_clr);
        if (e_clr) check(act_clr_idx == e_ci[IW-1:0], "R8 clear index", act_clr_idx, e_ci);
        check(act_set_valid == e_set, "R2 R3 R4 set request", act_set_valid, e_set);
        if (e_set) check(act_set_idx == offer_idx, "R4 set index", act_set_idx, offer_idx);

        @(posedge clk);
        #1;
        if (e_set) begin
            a[offer_idx] = 1;
            r[offer_idx] = 1;
            m_prio[offer_idx] = int'(offer_prio);
            m_vec[offer_idx]  = int'(offer_vec);
            m_lvl[offer_idx]  = offer_level;
        end
        if (tp_wr) m_tp = int'(tp_wdata);
        m_raised = r; m_serv = s; m_act = a; m_irq = irq;
        check(irq_out == m_irq, "R4 R6 R9 R11 irq line", irq_out, m_irq);
        check(int'(tp_rdata) == m_tp, "R10 threshold", tp_rdata, m_tp);
        offer_valid = 0; ack_rd = 0; eoi_wr = 0; tp_wr = 0;
    endtask

    task automatic go(bit ak, bit eo, bit ov, int oi, int op, int ovec, bit ol, bit tw, int tv);
        ack_rd = ak; eoi_wr = eo; offer_valid = ov;
        offer_idx = oi[IW-1:0]; offer_prio = op[4:0]; offer_vec = ovec[7:0];
        offer_level = ol; tp_wr = tw; tp_wdata = tv[3:0];
        cycle();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_raised = '0; m_serv = '0; m_act = '0; m_tp = 15; m_irq = 0;
        for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_vec[i] = 0; m_lvl[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check(irq_out == 0, "R1 reset line", irq_out, 0);
        check(tp_rdata == 4'hF, "R1 reset threshold", tp_rdata, 15);
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);                 // R1 empty ack: spurious
        go(0, 0, 1, 0, 10, 8'hAA, 0, 0, 0);            // R2 prio 10 <= 0xF dropped
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);                 // R2 not pending
        go(0, 0, 0, 0, 0, 0, 0, 1, 2);                 // R10 threshold 2
        go(0, 0, 1, 3, 5, 8'h33, 0, 0, 0);             // R4 accepted
        go(0, 0, 1, 3, 5, 8'h99, 0, 0, 0);             // R3 missed
        go(0, 0, 1, 5, 7, 8'h55, 1, 0, 0);
        go(0, 0, 1, 1, 7, 8'h11, 0, 0, 0);             // R5 tie
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);                 // R5 lowest index -> 0x11
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);                 // 0x55
        go(0, 1, 0, 0, 0, 0, 0, 0, 0);                 // R9 no reassert
        go(0, 1, 0, 0, 0, 0, 0, 0, 0);                 // R9 reassert
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);                 // R3 vector stays 0x33
        go(0, 1, 0, 0, 0, 0, 0, 0, 0);
        go(0, 0, 1, 2, 9, 8'h22, 1, 0, 0);
        m_act[2] = 0;                                  // R7 activity lost
        go(1, 0, 0, 0, 0, 0, 0, 0, 0);
        go(0, 0, 1, 7, 4, 8'h77, 1, 1, 6);             // R7 threshold then rises
        go(1, 0, 0, 0, 0, 0, 0, 1, 2);                 // R7 stale by priority
        go(0, 1, 0, 0, 0, 0, 0, 0, 0);
        go(0, 0, 1, 4, 6, 8'h44, 0, 0, 0);
        go(1, 0, 1, 6, 8, 8'h66, 1, 0, 0);             // R11 ack and offer together
        go(1, 1, 1, 4, 9, 8'h4F, 0, 0, 0);             // R11 all three
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 9) == 0) m_act[$urandom_range(0, N-1)] = 0;
            go($urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
               $urandom_range(0, 1) == 1, $urandom_range(0, N-1),
               $urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 1) == 1,
               $urandom_range(0, 19) == 0, $urandom_range(0, 5));
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule